// File: doc/BRIEF.md
# Root Port Status and Control Register

This block holds the 32-bit status and control word of one host-controller root port. Software reaches it through a simple register bus: an address, write data, a write strobe, a read strobe and registered read data. Each field of the word has its own access rule. Some bits are read-only status sampled from the port hardware. Some are plain read/write state. The port-reset request can only be set by software. The port-enable bit and the change flags can only be cleared by software, by writing a 1. A strobe bit gates writes to the link-state field, and the reserved bits always read as zero.

On the hardware side, level inputs report connection, over-current, speed and removability. Pulse inputs report a finished port reset, an enable fault, a finished warm reset, a configuration error and a link-state transition. Edges and pulses on these inputs update the status and raise the matching change flag. When a hardware set and a software clear of the same flag fall in the same cycle, the set wins, so no event is lost. Outputs carry the power, reset-request and link-state fields to the port logic. A one-cycle pulse marks every software link-state request.

Top module: `portsc_port_reg`

## Requirements
- R1: After reset every field reads 0, and port_power_o, port_reset_o, link_state_o and link_req_o are 0.
- R2: Connect (bit 0), over-current (bit 3), speed (bits 13:10) and removable (bit 30) follow the hardware inputs one clock later, and software writes to these bits have no effect.
- R3: Wake enables (bits 27:25), indicator control (bits 15:14) and power (bit 9) take the written value on every write: 1 sets them and 0 clears them. port_power_o shows bit 9.
- R4: Writing 1 to bit 4 sets the port-reset request, which appears on port_reset_o. Writing 0 to bit 4 has no effect.
- R5: Writing 1 to bit 1 clears port-enable, and writing 0 to it has no effect. Software can never set bit 1.
- R6: Change flags sit at bits 17 (connect), 18 (enable), 19 (warm reset), 20 (over-current), 21 (reset), 22 (link state) and 23 (config error). Writing 1 clears a flag and writing 0 leaves it. A hardware set in the same cycle as a software clear leaves the flag at 1.
- R7: The link-state field (bits 8:5) takes the written value only when bit 16 is 1 in the same write. Bit 16 reads as 0. Each such write pulses link_req_o high for one cycle. The field encodings are 0 for U0, 3 for U3 and 15 for resume.
- R8: Reserved bits 2, 24 and 31:28 read as 0 whatever was written.
- R9: Writing back a read value masked to bits 0, 3, 8:5, 9, 13:10, 15:14, 27:25 and 30 leaves the whole register unchanged.
- R10: A rising edge on hw_connect sets bit 0 and bit 17. A falling edge clears bits 0 and 1 and sets bit 17.
- R11: A hw_reset_done pulse while bit 4 is 1 clears bit 4, sets bit 1 and sets bit 21. The same pulse while bit 4 is 0 changes nothing.
- R12: A hw_link_evt pulse loads hw_link_state into bits 8:5 and sets bit 22. A software strobe write never sets bit 22.
- R13: A rising edge on hw_overcurrent sets bit 20. A hw_warm_done pulse sets bit 19. A hw_cfg_err pulse sets bit 23. A hw_enable_fault pulse clears bit 1 and sets bit 18.
- R14: Writes and reads to any address other than REG_ADDR are ignored, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| hw_connect | input | 1 | Device connected (level) |
| hw_overcurrent | input | 1 | Over-current active (level) |
| hw_speed | input | 4 | Port speed code (level) |
| hw_removable | input | 1 | Device removable (level) |
| hw_reset_done | input | 1 | Port reset finished (pulse) |
| hw_enable_fault | input | 1 | Port disabled by an error (pulse) |
| hw_warm_done | input | 1 | Warm reset finished (pulse) |
| hw_cfg_err | input | 1 | Configuration error (pulse) |
| hw_link_evt | input | 1 | Link-state transition (pulse) |
| hw_link_state | input | 4 | New link state that comes with hw_link_evt |
| port_power_o | output | 1 | Power field |
| port_reset_o | output | 1 | Port-reset request |
| link_state_o | output | 4 | Link-state field |
| link_req_o | output | 1 | One-cycle pulse after a software link-state write |

## Verification
A write takes effect at the clock edge that samples the strobe, and link_req_o rises at that same edge. A hardware edge or pulse is registered at the first edge after it arrives. A read captures the state at the edge that samples bus_rd and shows it on bus_rdata until the next edge. The bench drives inputs at falling edges and reads results back at the following falling edge, so every result is observed exactly one register stage after its cause. Same-cycle collisions, such as a hardware set against a software clear, are driven within a single clock period to check the stated priority.

// File: rtl/portsc_pkg.sv
package portsc_pkg;
  localparam int REG_W     = 32;
  localparam int LINK_W    = 4;
  localparam int SPD_W     = 4;
  localparam int IND_W     = 2;
  localparam int WAKE_W    = 3;
  localparam int CHG_N     = 7;

  // bit positions: the software view depends on these
  localparam int B_CONN    = 0;
  localparam int B_EN      = 1;
  localparam int B_OC      = 3;
  localparam int B_RST     = 4;
  localparam int B_LINK_LO = 5;
  localparam int B_PWR     = 9;
  localparam int B_SPD_LO  = 10;
  localparam int B_IND_LO  = 14;
  localparam int B_STRB    = 16;
  localparam int B_CHG_LO  = 17;
  localparam int B_WAKE_LO = 25;
  localparam int B_REMOV   = 30;

  // change-flag indices (flag i lives at bit B_CHG_LO + i)
  localparam int C_CONN = 0;
  localparam int C_EN   = 1;
  localparam int C_WARM = 2;
  localparam int C_OC   = 3;
  localparam int C_RST  = 4;
  localparam int C_LINK = 5;
  localparam int C_CFG  = 6;

  localparam logic [LINK_W-1:0] LS_U0     = 4'd0;
  localparam logic [LINK_W-1:0] LS_U3     = 4'd3;
  localparam logic [LINK_W-1:0] LS_RESUME = 4'd15;

  typedef struct packed {
    logic [WAKE_W-1:0] wake;
    logic [IND_W-1:0]  ind;
    logic              pwr;
  } rw_state_t;
endpackage

// File: rtl/portsc_edge.sv
module portsc_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= d;
  end

  always_comb begin
    rise = d & ~q_r;
    fall = ~d & q_r;
  end

  assign q = q_r;
endmodule

// File: rtl/portsc_chg.sv
module portsc_chg #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] q_r;
  logic [N-1:0] q_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // hardware set outranks a software clear in the same cycle
    always_comb q_d[i] = set[i] | (q_r[i] & ~clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r[i] <= 1'b0;
      else        q_r[i] <= q_d[i];
    end

    // R6: an event is never lost, whatever software writes alongside it
    p_set_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q_r[i]);
  end

  assign flags = q_r;
endmodule

// File: rtl/portsc_link.sv
module portsc_link #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_load,
  input  logic [W-1:0] sw_val,
  input  logic         hw_evt,
  input  logic [W-1:0] hw_val,
  output logic [W-1:0] state,
  output logic         req
);
  logic [W-1:0] st_q, st_d;
  logic         req_q;

  always_comb begin
    st_d = st_q;
    if (hw_evt)       st_d = hw_val;
    else if (sw_load) st_d = sw_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= sw_load;
    end
  end

  // R7: the field moves only on a strobed write or a hardware transition
  p_link_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_load && !hw_evt) |=> $stable(st_q));

  assign state = st_q;
  assign req   = req_q;
endmodule

// File: rtl/portsc_port_reg.sv
module portsc_port_reg
  import portsc_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              hw_connect,
  input  logic              hw_overcurrent,
  input  logic [SPD_W-1:0]  hw_speed,
  input  logic              hw_removable,
  input  logic              hw_reset_done,
  input  logic              hw_enable_fault,
  input  logic              hw_warm_done,
  input  logic              hw_cfg_err,
  input  logic              hw_link_evt,
  input  logic [LINK_W-1:0] hw_link_state,
  output logic              port_power_o,
  output logic              port_reset_o,
  output logic [LINK_W-1:0] link_state_o,
  output logic              link_req_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic wr_hit, rd_hit;
  assign wr_hit = bus_wr && (bus_addr == REG_ADDR);
  assign rd_hit = bus_rd && (bus_addr == REG_ADDR);

  // status levels with edge detection (index 0 connect, 1 over-current)
  logic [1:0] lvl_q, lvl_rise, lvl_fall;
  portsc_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .d({hw_overcurrent, hw_connect}),
    .q(lvl_q), .rise(lvl_rise), .fall(lvl_fall)
  );

  logic [SPD_W-1:0] spd_q;
  logic             remov_q;
  logic             en_q, en_d;
  logic             rst_q, rst_d;
  rw_state_t        rw_q, rw_d;
  logic             rst_done_hit;

  assign rst_done_hit = hw_reset_done && rst_q;

  // change flags
  logic [CHG_N-1:0] chg_set, chg_clr, chg_q;
  always_comb begin
    chg_set         = '0;
    chg_set[C_CONN] = lvl_rise[0] | lvl_fall[0];
    chg_set[C_EN]   = hw_enable_fault;
    chg_set[C_WARM] = hw_warm_done;
    chg_set[C_OC]   = lvl_rise[1];
    chg_set[C_RST]  = rst_done_hit;
    chg_set[C_LINK] = hw_link_evt;
    chg_set[C_CFG]  = hw_cfg_err;
    chg_clr         = wr_hit ? bus_wdata[B_CHG_LO +: CHG_N] : '0;
  end

  portsc_chg #(.N(CHG_N)) u_chg (
    .clk(clk), .rst_n(rst_sync_n), .set(chg_set), .clr(chg_clr), .flags(chg_q)
  );

  // link-state field
  logic [LINK_W-1:0] link_q;
  logic              link_req;
  portsc_link #(.W(LINK_W)) u_link (
    .clk(clk), .rst_n(rst_sync_n),
    .sw_load(wr_hit && bus_wdata[B_STRB]),
    .sw_val(bus_wdata[B_LINK_LO +: LINK_W]),
    .hw_evt(hw_link_evt), .hw_val(hw_link_state),
    .state(link_q), .req(link_req)
  );

  // next state of the local fields
  always_comb begin
    en_d  = (en_q & ~(wr_hit & bus_wdata[B_EN]) & ~lvl_fall[0] & ~hw_enable_fault)
            | rst_done_hit;
    rst_d = (rst_q & ~rst_done_hit) | (wr_hit & bus_wdata[B_RST]);
    rw_d  = rw_q;
    if (wr_hit) begin
      rw_d.wake = bus_wdata[B_WAKE_LO +: WAKE_W];
      rw_d.ind  = bus_wdata[B_IND_LO +: IND_W];
      rw_d.pwr  = bus_wdata[B_PWR];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      spd_q   <= '0;
      remov_q <= 1'b0;
      en_q    <= 1'b0;
      rst_q   <= 1'b0;
      rw_q    <= '0;
    end else begin
      spd_q   <= hw_speed;
      remov_q <= hw_removable;
      en_q    <= en_d;
      rst_q   <= rst_d;
      rw_q    <= rw_d;
    end
  end

  // software view; strobe and reserved positions stay zero
  logic [REG_W-1:0] view, rdata_d, rdata_q;
  always_comb begin
    view                          = '0;
    view[B_CONN]                  = lvl_q[0];
    view[B_EN]                    = en_q;
    view[B_OC]                    = lvl_q[1];
    view[B_RST]                   = rst_q;
    view[B_LINK_LO +: LINK_W]     = link_q;
    view[B_PWR]                   = rw_q.pwr;
    view[B_SPD_LO +: SPD_W]       = spd_q;
    view[B_IND_LO +: IND_W]       = rw_q.ind;
    view[B_CHG_LO +: CHG_N]       = chg_q;
    view[B_WAKE_LO +: WAKE_W]     = rw_q.wake;
    view[B_REMOV]                 = remov_q;
    rdata_d                       = rd_hit ? view : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:28], bus_wdata[24], bus_wdata[13:10],
                          bus_wdata[3:2], bus_wdata[0]};

  assign bus_rdata    = rdata_q;
  assign port_power_o = rw_q.pwr;
  assign port_reset_o = rst_q;
  assign link_state_o = link_q;
  assign link_req_o   = link_req;

  // R4: a write of 1 to the reset bit is not lost unless completion arrives
  p_reset_w1s_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_hit && bus_wdata[B_RST]) |=> port_reset_o);

  // R5/R11: enable only rises through a completed reset
  p_enable_src_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(en_q) |-> $past(hw_reset_done && port_reset_o));

  // R10: any change of the connect level raises the connect change flag
  p_conn_chg_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hw_connect != lvl_q[0]) |=> chg_q[C_CONN]);

  // R12: only the hardware raises the link change flag
  p_plc_hw_only_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!hw_link_evt && !chg_q[C_LINK]) |=> !chg_q[C_LINK]);

  // R7: every request pulse follows a strobed write
  p_link_req_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_req_o |-> $past(wr_hit && bus_wdata[B_STRB]));
endmodule

// File: tb/sim_portsc_port_reg.sv
`timescale 1ns/1ps
module sim_portsc_port_reg;
  localparam logic [7:0]  A   = 8'h20;
  localparam logic [31:0] KEEP = 32'h4E00FFE9;
  localparam logic [31:0] RSVD = 32'hF1010004;

  // {write data, expected read-back}, walked from a fresh reset
  localparam logic [63:0] VEC [6] = '{
    {32'h0E00C200, 32'h0E00C200},  // R3 set all plain bits
    {32'hFFFFFFFF, 32'h0E00C3F0},  // R2 R4 R7 R8 all ones
    {32'h00000000, 32'h000001F0},  // R3 clear, R4 reset held, R7 no strobe
    {32'h00010060, 32'h00000070},  // R7 strobe loads U3
    {32'h000000A0, 32'h00000070},  // R7 no strobe, field kept
    {32'h00010000, 32'h00000010}   // R7 strobe loads U0
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_wr, bus_rd;
  logic        hw_connect, hw_overcurrent, hw_removable;
  logic [3:0]  hw_speed, hw_link_state, link_state_o;
  logic        hw_reset_done, hw_enable_fault, hw_warm_done, hw_cfg_err, hw_link_evt;
  logic        port_power_o, port_reset_o, link_req_o;

  portsc_port_reg #(.ADDR_W(8), .REG_ADDR(A)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hw_connect(hw_connect), .hw_overcurrent(hw_overcurrent), .hw_speed(hw_speed),
    .hw_removable(hw_removable), .hw_reset_done(hw_reset_done),
    .hw_enable_fault(hw_enable_fault), .hw_warm_done(hw_warm_done),
    .hw_cfg_err(hw_cfg_err), .hw_link_evt(hw_link_evt), .hw_link_state(hw_link_state),
    .port_power_o(port_power_o), .port_reset_o(port_reset_o),
    .link_state_o(link_state_o), .link_req_o(link_req_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_v, rd_v;

  task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic apply_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bus_addr = A; bus_wdata = '0; bus_wr = 0; bus_rd = 0;
    hw_connect = 0; hw_overcurrent = 0; hw_removable = 0; hw_speed = 0;
    hw_reset_done = 0; hw_enable_fault = 0; hw_warm_done = 0; hw_cfg_err = 0;
    hw_link_evt = 0; hw_link_state = 0;
    apply_reset();

    do_read(A, rd_v);
    chk(rd_v, 32'h0, "R1 reset value");
    chk({28'h0, port_power_o, port_reset_o, link_req_o, 1'b0} | {28'h0, link_state_o},
        32'h0, "R1 outputs after reset");

    for (int i = 0; i < 6; i++) begin
      do_write(A, VEC[i][63:32]);
      do_read(A, rd_v);
      chk(rd_v, VEC[i][31:0], $sformatf("R3/R4/R7 vector %0d", i));
    end
    chk(rd_v & RSVD, 32'h0, "R8 reserved read zero");
    exp_v = 32'h00000010;

    // connect rise with speed and removable
    @(negedge clk); hw_connect = 1; hw_speed = 4'd4; hw_removable = 1;
    exp_v = exp_v | 32'h40021001;
    do_read(A, rd_v); chk(rd_v, exp_v, "R10 connect rise / R2 status");

    do_write(A, 32'h40003C09 & ~32'h1);
    do_read(A, rd_v); chk(rd_v, exp_v, "R2 read-only ignores writes");

    do_write(A, 32'h00020000); exp_v &= ~32'h00020000;
    do_read(A, rd_v); chk(rd_v, exp_v, "R6 connect change cleared");

    @(negedge clk); hw_reset_done = 1; @(negedge clk); hw_reset_done = 0;
    exp_v = (exp_v & ~32'h10) | 32'h00200002;
    do_read(A, rd_v); chk(rd_v, exp_v, "R11 reset done");
    chk({31'h0, port_reset_o}, 32'h0, "R4 reset output cleared");

    @(negedge clk); hw_reset_done = 1; @(negedge clk); hw_reset_done = 0;
    do_read(A, rd_v); chk(rd_v, exp_v, "R11 reset done without request");

    do_write(A, 32'h0);
    do_read(A, rd_v); chk(rd_v, exp_v, "R5 zero write keeps enable");

    do_write(A, 32'h00000200); exp_v |= 32'h200;
    do_read(A, rd_v); chk(rd_v, exp_v, "R3 power set");
    chk({31'h0, port_power_o}, 32'h1, "R3 power output");

    do_write(A, rd_v & KEEP);
    do_read(A, rd_v); chk(rd_v, exp_v, "R9 neutral write-back");

    do_write(A, (exp_v & KEEP) | 32'h00200002); exp_v &= ~32'h00200002;
    do_read(A, rd_v); chk(rd_v, exp_v, "R5 enable cleared by write one");

    @(negedge clk); hw_link_state = 4'd3; hw_link_evt = 1; @(negedge clk); hw_link_evt = 0;
    exp_v = (exp_v & ~32'h1E0) | 32'h00400060;
    do_read(A, rd_v); chk(rd_v, exp_v, "R12 hardware link event");

    do_write(A, (exp_v & KEEP) | 32'h00400000); exp_v &= ~32'h00400000;
    do_read(A, rd_v); chk(rd_v, exp_v, "R6 link change cleared");

    do_write(A, (exp_v & KEEP & ~32'h1E0) | 32'h000101E0);
    chk({31'h0, link_req_o}, 32'h1, "R7 request pulse high");
    @(negedge clk);
    chk({31'h0, link_req_o}, 32'h0, "R7 request pulse ends");
    exp_v |= 32'h1E0;
    do_read(A, rd_v); chk(rd_v, exp_v, "R12 strobe write leaves change flag");
    chk({28'h0, link_state_o}, 32'hF, "R7 resume on output");

    @(negedge clk); hw_overcurrent = 1;
    exp_v |= 32'h00100008;
    do_read(A, rd_v); chk(rd_v, exp_v, "R13 over-current rise");

    @(negedge clk); hw_warm_done = 1; hw_cfg_err = 1;
    @(negedge clk); hw_warm_done = 0; hw_cfg_err = 0;
    exp_v |= 32'h00880000;
    do_read(A, rd_v); chk(rd_v, exp_v, "R13 warm and config flags");

    do_write(A, (exp_v & KEEP) | 32'h10);
    @(negedge clk); hw_reset_done = 1; @(negedge clk); hw_reset_done = 0;
    @(negedge clk); hw_enable_fault = 1; @(negedge clk); hw_enable_fault = 0;
    exp_v |= 32'h00240000;
    do_read(A, rd_v); chk(rd_v, exp_v, "R13 enable fault");

    // same-cycle hardware set against software clear
    @(negedge clk);
    bus_addr = A; bus_wdata = (exp_v & KEEP) | 32'h00800000; bus_wr = 1; hw_cfg_err = 1;
    @(negedge clk);
    bus_wr = 0; hw_cfg_err = 0;
    do_read(A, rd_v); chk(rd_v, exp_v, "R6 set wins over clear");

    do_write(A, (exp_v & KEEP) | 32'h10);
    @(negedge clk); hw_reset_done = 1; @(negedge clk); hw_reset_done = 0;
    @(negedge clk); hw_connect = 0;
    exp_v = (exp_v & ~32'h1) | 32'h00020000;
    do_read(A, rd_v); chk(rd_v, exp_v, "R10 disconnect clears enable");

    do_write(8'h21, 32'hFFFFFFFF);
    do_read(A, rd_v); chk(rd_v, exp_v, "R14 foreign write ignored");
    do_read(8'h21, rd_v); chk(rd_v, 32'h0, "R14 foreign read zero");

    @(negedge clk);
    hw_overcurrent = 0; hw_removable = 0; hw_speed = 0; hw_link_state = 0;
    apply_reset();
    do_read(A, rd_v); chk(rd_v, 32'h0, "R1 reset mid-run");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule